// File: doc/BRIEF.md
# Prioritised Capability Access Checker

This block judges a single memory or instruction-fetch access against the capability that authorises it. Every check runs in parallel in one cycle: the validity tag, the sealed state, the object-type state, the permission bits that the access kind demands, the bounds, and the software-defined permission bits. When one or more checks fail, the block reports one fault with the architected cause code of the highest-ranked failing check. When none fails, it grants the access.

An access is presented as a one-cycle request strobe with its kind, address, byte size and the fields of the authorising capability. The verdict (grant or fault) and the 5-bit cause come out of a register one cycle after the strobe. A load/store unit or fetch stage samples the verdict in that cycle and turns a fault into a precise trap. Cycles without a request produce no verdict.

Top module: `cap_access_checker`

## Requirements
- R1: A cycle with `req_i` high is followed one cycle later by exactly one of `grant_o` or `fault_o`. A cycle with `req_i` low is followed by both low and `cause_o` zero. All three outputs are low during reset.
- R2: When no check fails the access is granted, and `cause_o` is zero.
- R3: An untagged capability (`cap_tag_i` low) always faults with cause 0x02. This check outranks all others.
- R4: A sealed capability faults with cause 0x03. Otherwise, a capability whose `cap_otype_ok_i` is low faults with cause 0x04. Both rank directly below the tag check.
- R5: If `need_invoke_i` is set and permission bit 7 is clear, the cause is 0x19. If `need_cid_i` is set and permission bit 8 is clear, the cause is 0x1c. Both share one rank below the type check, and 0x19 wins when both fail.
- R6: The kind encodings are load 0, store 1, capability load 2, capability store 3, execute 4. Execute needs permission bit 1 (cause 0x11). Kinds 0 and 2 need bit 2 (cause 0x12). Kinds 1 and 3 need bit 3 (cause 0x13). These rank in that order, below R5.
- R7: A capability load also needs bit 4 (cause 0x14). A capability store also needs bit 5 (cause 0x15). A capability store whose stored value is tagged (`st_tag_i`) and local (`st_local_i`) also needs bit 6 (cause 0x16). These rank in that order, below R6.
- R8: If `need_global_i` is set and permission bit 0 is clear, the cause is 0x10. This ranks below R7.
- R9: A length fault (cause 0x01) occurs when addr < base or addr + size > base + length, computed with one extra bit so that no sum wraps. It ranks below R8.
- R10: Any bit set in `sw_req_i` but clear in `cap_sw_perms_i` gives cause 0x08. This is the lowest rank.
- R11: The codes 0x0a, 0x17 and 0x1b are never driven on `cause_o`.
- R12: When several checks fail together, the cause reported is the code of the highest-ranked failing check in the order R3, R4, R5, R6, R7, R8, R9, R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| kind_i | input | 3 | Access kind (0 ld, 1 st, 2 cap ld, 3 cap st, 4 exec) |
| addr_i | input | AW | Access address |
| size_i | input | SZW | Access size in bytes |
| cap_tag_i | input | 1 | Capability validity tag |
| cap_sealed_i | input | 1 | Capability is sealed |
| cap_otype_ok_i | input | 1 | Object type is valid |
| cap_perms_i | input | 9 | Hardware permission bits |
| cap_sw_perms_i | input | SWW | Software-defined permission bits |
| cap_base_i | input | AW | Capability base |
| cap_len_i | input | AW | Capability length |
| need_invoke_i | input | 1 | Access requires invoke permission |
| need_cid_i | input | 1 | Access requires compartment-ID permission |
| need_global_i | input | 1 | Access requires global permission |
| st_tag_i | input | 1 | Stored capability is tagged |
| st_local_i | input | 1 | Stored capability is local |
| sw_req_i | input | SWW | Software-defined permissions demanded |
| grant_o | output | 1 | Access granted (one cycle after request) |
| fault_o | output | 1 | Access faults (one cycle after request) |
| cause_o | output | 5 | Cause code of the reported fault |

## Verification
All three outputs come from one register stage, so each verdict belongs to the cycle after its strobe. Cycles with no strobe must show an idle output in that same following cycle. The bench drives each access on a falling edge and computes the expected verdict at the next rising edge from the inputs it just drove. It then compares at the following falling edge, one register later, so every cycle is checked against the access of the previous cycle. Directed cases pile up failures from adjacent ranks to pin down the order, and place addresses exactly on both bound limits. Random accesses fill in the rest.

// File: rtl/capchk_pkg.sv
package capchk_pkg;
  localparam int PERM_W = 9;
  localparam int P_GLOB = 0;
  localparam int P_EXEC = 1;
  localparam int P_LOAD = 2;
  localparam int P_STOR = 3;
  localparam int P_LDC  = 4;
  localparam int P_STC  = 5;
  localparam int P_STLC = 6;
  localparam int P_INV  = 7;
  localparam int P_CID  = 8;

  localparam logic [2:0] K_LD  = 3'd0;
  localparam logic [2:0] K_ST  = 3'd1;
  localparam logic [2:0] K_LDC = 3'd2;
  localparam logic [2:0] K_STC = 3'd3;
  localparam logic [2:0] K_EXE = 3'd4;

  // check slots, index 0 ranks highest
  localparam int C_TAG  = 0;
  localparam int C_SEAL = 1;
  localparam int C_TYPE = 2;
  localparam int C_INV  = 3;
  localparam int C_CID  = 4;
  localparam int C_EXEC = 5;
  localparam int C_LOAD = 6;
  localparam int C_STOR = 7;
  localparam int C_LDC  = 8;
  localparam int C_STC  = 9;
  localparam int C_STLC = 10;
  localparam int C_GLOB = 11;
  localparam int C_LEN  = 12;
  localparam int C_SW   = 13;
  localparam int NUM_CHK = 14;

  localparam int CAUSE_W = 5;

  function automatic logic [CAUSE_W-1:0] slot_code(input int idx);
    case (idx)
      C_TAG:   slot_code = 5'h02;
      C_SEAL:  slot_code = 5'h03;
      C_TYPE:  slot_code = 5'h04;
      C_INV:   slot_code = 5'h19;
      C_CID:   slot_code = 5'h1c;
      C_EXEC:  slot_code = 5'h11;
      C_LOAD:  slot_code = 5'h12;
      C_STOR:  slot_code = 5'h13;
      C_LDC:   slot_code = 5'h14;
      C_STC:   slot_code = 5'h15;
      C_STLC:  slot_code = 5'h16;
      C_GLOB:  slot_code = 5'h10;
      C_LEN:   slot_code = 5'h01;
      C_SW:    slot_code = 5'h08;
      default: slot_code = 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/cap_chk_bounds.sv
module cap_chk_bounds #(
  parameter int AW  = 32,
  parameter int SZW = 4
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [SZW-1:0] size_i,
  input  logic [AW-1:0]  base_i,
  input  logic [AW-1:0]  len_i,
  output logic           len_viol_o
);
  localparam int EW = AW + 1;

  logic [EW-1:0] lo_ext, top_ext, end_ext;

  assign lo_ext  = {1'b0, addr_i};
  assign end_ext = lo_ext + EW'(size_i);
  assign top_ext = {1'b0, base_i} + {1'b0, len_i};

  assign len_viol_o = (lo_ext < {1'b0, base_i}) || (end_ext > top_ext);
endmodule

// File: rtl/cap_chk_perm.sv
module cap_chk_perm
  import capchk_pkg::*;
#(
  parameter int SWW = 4
) (
  input  logic              tag_i,
  input  logic              sealed_i,
  input  logic              otype_ok_i,
  input  logic [PERM_W-1:0] perms_i,
  input  logic [SWW-1:0]    sw_perms_i,
  input  logic [2:0]        kind_i,
  input  logic              need_inv_i,
  input  logic              need_cid_i,
  input  logic              need_glob_i,
  input  logic              st_tag_i,
  input  logic              st_local_i,
  input  logic [SWW-1:0]    sw_req_i,
  input  logic              len_viol_i,
  output logic [NUM_CHK-1:0] viol_o
);
  logic k_ld, k_st, k_ldc, k_stc, k_exe;

  assign k_ld  = (kind_i == K_LD);
  assign k_st  = (kind_i == K_ST);
  assign k_ldc = (kind_i == K_LDC);
  assign k_stc = (kind_i == K_STC);
  assign k_exe = (kind_i == K_EXE);

  always_comb begin
    viol_o         = '0;
    viol_o[C_TAG]  = ~tag_i;
    viol_o[C_SEAL] = sealed_i;
    viol_o[C_TYPE] = ~otype_ok_i;
    viol_o[C_INV]  = need_inv_i & ~perms_i[P_INV];
    viol_o[C_CID]  = need_cid_i & ~perms_i[P_CID];
    viol_o[C_EXEC] = k_exe & ~perms_i[P_EXEC];
    viol_o[C_LOAD] = (k_ld | k_ldc) & ~perms_i[P_LOAD];
    viol_o[C_STOR] = (k_st | k_stc) & ~perms_i[P_STOR];
    viol_o[C_LDC]  = k_ldc & ~perms_i[P_LDC];
    viol_o[C_STC]  = k_stc & ~perms_i[P_STC];
    viol_o[C_STLC] = k_stc & st_tag_i & st_local_i & ~perms_i[P_STLC];
    viol_o[C_GLOB] = need_glob_i & ~perms_i[P_GLOB];
    viol_o[C_LEN]  = len_viol_i;
    viol_o[C_SW]   = |(sw_req_i & ~sw_perms_i);
  end
endmodule

// File: rtl/cap_chk_prio.sv
module cap_chk_prio
  import capchk_pkg::*;
#(
  parameter int N = NUM_CHK
) (
  input  logic [N-1:0]       viol_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] code_o
);
  logic [N-1:0]       hit;
  logic [CAUSE_W-1:0] slot_val [N];

  // one-hot winner: slot i wins when nothing above it fails
  for (genvar i = 0; i < N; i++) begin : g_slot
    if (i == 0) begin : g_top
      assign hit[i] = viol_i[i];
    end else begin : g_rest
      assign hit[i] = viol_i[i] & ~|viol_i[i-1:0];
    end
    assign slot_val[i] = hit[i] ? slot_code(i) : '0;
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) code_o = code_o | slot_val[i];
  end

  assign any_o = |viol_i;
endmodule

// File: rtl/cap_access_checker.sv
module cap_access_checker
  import capchk_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SZW = 4,
  parameter int SWW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [SZW-1:0]    size_i,
  input  logic              cap_tag_i,
  input  logic              cap_sealed_i,
  input  logic              cap_otype_ok_i,
  input  logic [8:0]        cap_perms_i,
  input  logic [SWW-1:0]    cap_sw_perms_i,
  input  logic [AW-1:0]     cap_base_i,
  input  logic [AW-1:0]     cap_len_i,
  input  logic              need_invoke_i,
  input  logic              need_cid_i,
  input  logic              need_global_i,
  input  logic              st_tag_i,
  input  logic              st_local_i,
  input  logic [SWW-1:0]    sw_req_i,
  output logic              grant_o,
  output logic              fault_o,
  output logic [4:0]        cause_o
);
  logic                len_viol;
  logic [NUM_CHK-1:0]  viol;
  logic                any_viol;
  logic [CAUSE_W-1:0]  code;

  cap_chk_bounds #(.AW(AW), .SZW(SZW)) u_bounds (
    .addr_i     (addr_i),
    .size_i     (size_i),
    .base_i     (cap_base_i),
    .len_i      (cap_len_i),
    .len_viol_o (len_viol)
  );

  cap_chk_perm #(.SWW(SWW)) u_perm (
    .tag_i       (cap_tag_i),
    .sealed_i    (cap_sealed_i),
    .otype_ok_i  (cap_otype_ok_i),
    .perms_i     (cap_perms_i),
    .sw_perms_i  (cap_sw_perms_i),
    .kind_i      (kind_i),
    .need_inv_i  (need_invoke_i),
    .need_cid_i  (need_cid_i),
    .need_glob_i (need_global_i),
    .st_tag_i    (st_tag_i),
    .st_local_i  (st_local_i),
    .sw_req_i    (sw_req_i),
    .len_viol_i  (len_viol),
    .viol_o      (viol)
  );

  cap_chk_prio #(.N(NUM_CHK)) u_prio (
    .viol_i (viol),
    .any_o  (any_viol),
    .code_o (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= '0;
    end else begin
      grant_o <= req_i & ~any_viol;
      fault_o <= req_i & any_viol;
      cause_o <= (req_i & any_viol) ? code : '0;
    end
  end
endmodule

// File: rtl/cap_chk_sva.sv
module cap_chk_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       cap_tag_i,
  input logic       cap_sealed_i,
  input logic       grant_o,
  input logic       fault_o,
  input logic [4:0] cause_o
);
  a_r1_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (grant_o ^ fault_o));

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!grant_o && !fault_o && cause_o == 5'h00));

  a_r2_grant_no_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> cause_o == 5'h00);

  a_r3_untagged_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !cap_tag_i) |=> (fault_o && cause_o == 5'h02));

  a_r4_sealed_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cap_tag_i && cap_sealed_i) |=> (fault_o && cause_o == 5'h03));

  a_r11_no_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cause_o == 5'h0a || cause_o == 5'h17 || cause_o == 5'h1b));
endmodule

bind cap_access_checker cap_chk_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .cap_tag_i    (cap_tag_i),
  .cap_sealed_i (cap_sealed_i),
  .grant_o      (grant_o),
  .fault_o      (fault_o),
  .cause_o      (cause_o)
);

// File: tb/cap_access_checker_tb.sv
module cap_access_checker_tb;
  localparam int AW = 32, SZW = 4, SWW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic            req = 0;
  logic [2:0]      kind = 0;
  logic [AW-1:0]   addr = 0, base = 0, len = 0;
  logic [SZW-1:0]  size = 0;
  logic            tag = 0, sealed = 0, ot_ok = 0;
  logic [8:0]      perms = 0;
  logic [SWW-1:0]  swp = 0, swr = 0;
  logic            n_inv = 0, n_cid = 0, n_glob = 0, st_tag = 0, st_loc = 0;
  logic            grant, fault;
  logic [4:0]      cause;

  int n_run = 0, n_fail = 0;
  logic       exp_g, exp_f;
  logic [4:0] exp_c;

  cap_access_checker #(.AW(AW), .SZW(SZW), .SWW(SWW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .kind_i(kind), .addr_i(addr),
    .size_i(size), .cap_tag_i(tag), .cap_sealed_i(sealed), .cap_otype_ok_i(ot_ok),
    .cap_perms_i(perms), .cap_sw_perms_i(swp), .cap_base_i(base), .cap_len_i(len),
    .need_invoke_i(n_inv), .need_cid_i(n_cid), .need_global_i(n_glob),
    .st_tag_i(st_tag), .st_local_i(st_loc), .sw_req_i(swr),
    .grant_o(grant), .fault_o(fault), .cause_o(cause));

  // behavioural reference: walk the checks in rank order
  function automatic logic [4:0] ref_cause();
    longint unsigned a = addr, b = base, l = len, s = size;
    if (!tag) return 5'h02;
    if (sealed) return 5'h03;
    if (!ot_ok) return 5'h04;
    if (n_inv && !perms[7]) return 5'h19;
    if (n_cid && !perms[8]) return 5'h1c;
    if (kind == 4 && !perms[1]) return 5'h11;
    if ((kind == 0 || kind == 2) && !perms[2]) return 5'h12;
    if ((kind == 1 || kind == 3) && !perms[3]) return 5'h13;
    if (kind == 2 && !perms[4]) return 5'h14;
    if (kind == 3 && !perms[5]) return 5'h15;
    if (kind == 3 && st_tag && st_loc && !perms[6]) return 5'h16;
    if (n_glob && !perms[0]) return 5'h10;
    if (a < b || a + s > b + l) return 5'h01;
    if ((swr & ~swp) != 0) return 5'h08;
    return 5'h00;
  endfunction

  function automatic string req_of(input logic [4:0] c);
    case (c)
      5'h02: return "R3";
      5'h03, 5'h04: return "R4";
      5'h19, 5'h1c: return "R5";
      5'h11, 5'h12, 5'h13: return "R6";
      5'h14, 5'h15, 5'h16: return "R7";
      5'h10: return "R8";
      5'h01: return "R9";
      5'h08: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", rq, act, expv, $time);
    end
  endtask

  // one access per cycle: drive, latch expectation at posedge, compare at negedge
  task automatic cycle();
    @(posedge clk);
    if (req) begin
      exp_c = ref_cause();
      exp_g = (exp_c == 5'h00);
      exp_f = (exp_c != 5'h00);
    end else begin
      exp_c = 0; exp_g = 0; exp_f = 0;
    end
    @(negedge clk);
    check(grant == exp_g && fault == exp_f, "R1", {grant, fault}, {exp_g, exp_f});
    check(cause == exp_c, exp_c == 0 ? "R2" : {req_of(exp_c), " (R12 order)"}, cause, exp_c);
    check(!(cause == 5'h0a || cause == 5'h17 || cause == 5'h1b), "R11", cause, 0);
  endtask

  task automatic good(input logic [2:0] k);
    req = 1; kind = k; tag = 1; sealed = 0; ot_ok = 1; perms = 9'h1ff;
    swp = 4'hf; swr = 4'h3; n_inv = 0; n_cid = 0; n_glob = 1; st_tag = 1; st_loc = 1;
    base = 32'h1000; len = 32'h100; addr = 32'h1010; size = 4'd8;
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!grant && !fault && cause == 0, "R1 reset", {grant, fault, cause}, 0);
    rst_ni = 1;
    @(negedge clk);
    // idle cycle
    req = 0; cycle();
    // R2 clean grants for every kind
    for (int k = 0; k < 5; k++) begin good(3'(k)); cycle(); end
    // R3 untagged beats everything
    good(3'd3); tag = 0; sealed = 1; perms = 0; addr = 0; cycle();
    // R4 seal over type, then type alone
    good(3'd0); sealed = 1; ot_ok = 0; cycle();
    good(3'd0); ot_ok = 0; perms = 0; cycle();
    // R5 invoke wins tie with cid; cid alone
    good(3'd4); n_inv = 1; n_cid = 1; perms = 9'h000; cycle();
    good(3'd4); n_cid = 1; perms = 9'h0ff; cycle();
    // R6 exec / load / store
    good(3'd4); perms[1] = 0; perms[0] = 0; cycle();
    good(3'd2); perms[2] = 0; perms[4] = 0; cycle();
    good(3'd3); perms[3] = 0; perms[5] = 0; cycle();
    // R7 cap load, cap store, local store
    good(3'd2); perms[4] = 0; addr = 0; cycle();
    good(3'd3); perms[5] = 0; perms[6] = 0; cycle();
    good(3'd3); perms[6] = 0; cycle();
    good(3'd3); perms[6] = 0; st_loc = 0; cycle();
    // R8 global
    good(3'd1); perms[0] = 0; addr = 0; cycle();
    // R9 bounds edges
    good(3'd0); addr = 32'h10f8; size = 4'd8; cycle();
    good(3'd0); addr = 32'h10f9; size = 4'd8; cycle();
    good(3'd0); addr = 32'h0fff; size = 4'd1; cycle();
    good(3'd0); addr = 32'h1000; size = 4'd0; cycle();
    good(3'd0); base = 32'hffff_fff0; len = 32'h20; addr = 32'hffff_fffc; size = 4'd4; cycle();
    good(3'd0); base = 32'hffff_fff0; len = 32'h0f; addr = 32'hffff_fffc; size = 4'd4; cycle();
    // R10 software perms, lowest rank
    good(3'd1); swp = 4'h1; swr = 4'h3; cycle();
    good(3'd1); swp = 4'h1; swr = 4'h3; addr = 32'h2000; cycle();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      req = ($urandom % 8) != 0;
      kind = 3'($urandom % 5);
      tag = ($urandom % 16) != 0; sealed = ($urandom % 16) == 0; ot_ok = ($urandom % 16) != 0;
      perms = ($urandom % 2) ? 9'h1ff : 9'($urandom);
      swp = 4'($urandom); swr = ($urandom % 2) ? 4'h0 : 4'($urandom);
      n_inv = $urandom % 2; n_cid = $urandom % 2; n_glob = $urandom % 2;
      st_tag = $urandom % 2; st_loc = $urandom % 2;
      base = $urandom; len = 32'($urandom % 512);
      addr = base + 32'($urandom % 600) - 32'd40; size = 4'($urandom);
      cycle();
    end
    req = 0; cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule